// File: doc/BRIEF.md
# Pin Interrupt Sensing Controller

This block gathers general-purpose pin inputs from several 16-pin ports and turns them into one parent interrupt line. Each port splits into two 8-pin halves. An assignment register chooses which port drives each byte of a 32-bit sense vector. Lower halves can only reach the even bytes, and upper halves can only reach the odd bytes. Every sensed bit passes through a two-flop synchronizer. It can then be complemented, and it is detected either on a rising edge or as an active-high level. A pending request that is enabled drives the interrupt output.

Software programs the block through a small word-addressed register file. The mask, edge-mode and invert bits each have a set register and a clear register, and a read of either register returns the current state. Pending requests are cleared by writing ones to the request register. The same rising-edge detector therefore serves for falling edges and low levels: software sets the invert bit for that pin.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset the mask, request, assignment, edge and invert registers all read zero, and `irq_o` is low.
- R2: Byte b of the sense vector takes the pins of the port whose index equals assignment bits [8b+7:8b]. Even bytes take that port's pins 0..7, and odd bytes take its pins 8..15. A code that is not below NUM_PORTS gives zeros. Word 8 (byte address 0x20) reads the sense vector XOR the invert bits.
- R3: The set registers are mask at word 0, edge at word 4 and invert at word 6. The clear registers are mask at word 1, edge at word 5 and invert at word 7. A write sets or clears only the bits written as 1. A read of either register of a pair returns the current bits.
- R4: When a bit's edge bit is 1, its request latches on a 0-to-1 change of input XOR invert. That is a rising edge with invert 0 and a falling edge with invert 1. The request stays latched after the input returns.
- R5: Changing an invert bit does not create an edge request by itself.
- R6: Writing word 2 clears the request bits written as 1 and leaves the other request bits unchanged. Word 2 reads the request bits.
- R7: When a bit's edge bit is 0, its request is set every cycle in which input XOR invert is 1. A clear has no effect while that value stays 1. The request stays latched after the level drops, until it is cleared.
- R8: An edge that arrives in the same cycle as a clear of that bit leaves the request set.
- R9: `irq_o` is high exactly when some request bit has its mask bit set. Masked requests still latch.
- R10: Word 3 is the assignment register. All 32 bits can be written and read back.
- R11: A pin change reaches the request register on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PORTS*16 | Raw pin inputs; port p occupies bits 16p+15:16p |
| bus_addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | Parent interrupt |

## Verification
The bench builds the block with NUM_PORTS set to 3. Map code 3 is then the smallest code that names no port, so the out-of-range routing case is covered next to every real port. With three ports and four bytes, the bench can sweep every byte against every code from 0 to 3, with and without inversion, and predict each sense value by arithmetic. The exact-cycle checks on synchronizer latency and on an edge that coincides with a clear also stay small at this size.

// File: rtl/pin_irq_sense.sv
module pin_irq_sense #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*16-1:0]    pin_i,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       irq_o
);
  localparam int PORT_W  = 16;
  localparam int HALF_W  = PORT_W / 2;
  localparam int VEC_W   = 2 * PORT_W;
  localparam int NBYTES  = VEC_W / HALF_W;
  localparam int PIN_W   = NUM_PORTS * PORT_W;
  localparam int WORD_W  = ADDR_W - 2;

  localparam logic [WORD_W-1:0] W_MSET = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_MCLR = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_REQ  = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_ASGN = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_ESET = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_ECLR = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_ISET = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_ICLR = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_SNS  = WORD_W'(8);

  logic [PIN_W-1:0] sync1_q, sync2_q;
  logic [VEC_W-1:0] mask_q, edge_q, inv_q, req_q, prev_q;
  logic [VEC_W-1:0] asgn_q;
  logic [VEC_W-1:0] routed, sensed, edge_hit, level_hit, w1c;
  logic [WORD_W-1:0] word;
  logic unused_addr_bits;

  assign word             = bus_addr[ADDR_W-1:2];
  assign unused_addr_bits = ^bus_addr[1:0];

  always_comb begin
    routed = '0;
    for (int b = 0; b < NBYTES; b++)
      for (int p = 0; p < NUM_PORTS; p++)
        if (asgn_q[b*HALF_W +: HALF_W] == HALF_W'(p))
          routed[b*HALF_W +: HALF_W] = sync2_q[p*PORT_W + (b%2)*HALF_W +: HALF_W];
  end

  assign sensed    = routed ^ inv_q;
  assign edge_hit  = edge_q & sensed & ~(prev_q ^ inv_q);
  assign level_hit = ~edge_q & sensed;
  assign w1c       = (bus_we && word == W_REQ) ? bus_wdata : '0;
  assign irq_o     = |(req_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      req_q   <= '0;
      mask_q  <= '0;
      edge_q  <= '0;
      inv_q   <= '0;
      asgn_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= routed;
      req_q   <= (req_q & ~w1c) | edge_hit | level_hit;
      if (bus_we) begin
        case (word)
          W_MSET:  mask_q <= mask_q | bus_wdata;
          W_MCLR:  mask_q <= mask_q & ~bus_wdata;
          W_ESET:  edge_q <= edge_q | bus_wdata;
          W_ECLR:  edge_q <= edge_q & ~bus_wdata;
          W_ISET:  inv_q  <= inv_q | bus_wdata;
          W_ICLR:  inv_q  <= inv_q & ~bus_wdata;
          W_ASGN:  asgn_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      W_MSET, W_MCLR: bus_rdata = mask_q;
      W_ESET, W_ECLR: bus_rdata = edge_q;
      W_ISET, W_ICLR: bus_rdata = inv_q;
      W_REQ:          bus_rdata = req_q;
      W_ASGN:         bus_rdata = asgn_q;
      W_SNS:          bus_rdata = sensed;
      default:        bus_rdata = '0;
    endcase
  end

  AST_REQ_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && word == W_REQ) |=> ((req_q & $past(req_q)) == $past(req_q))); // R6
  AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((req_q & $past(level_hit)) == $past(level_hit))); // R7
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((req_q & $past(edge_hit)) == $past(edge_hit))); // R8
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && word == W_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && word == W_MCLR) |=> ((mask_q & $past(bus_wdata)) == '0)); // R3
  AST_ASSIGN_WR: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && word == W_ASGN) |=> (asgn_q == $past(bus_wdata))); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == '0) |-> !irq_o); // R9
endmodule

// File: tb/tb_pin_irq_sense.sv
module tb_pin_irq_sense;
  localparam int NP = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*16-1:0] pin_i = '0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_irq_sense #(.NUM_PORTS(NP), .ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  localparam logic [5:0] A_MSET = 6'h00, A_MCLR = 6'h04, A_REQ = 6'h08, A_ASGN = 6'h0C;
  localparam logic [5:0] A_ESET = 6'h10, A_ECLR = 6'h14, A_ISET = 6'h18, A_ICLR = 6'h1C, A_SNS = 6'h20;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rdchk(string tag, logic [5:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pv(int p, int h);
    return 8'((p * 2 + h + 1) * 37);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rdchk("R1 mask", A_MSET, 32'h0);
    rdchk("R1 req", A_REQ, 32'h0);
    rdchk("R1 assign", A_ASGN, 32'h0);
    rdchk("R1 edge", A_ESET, 32'h0);
    rdchk("R1 inv", A_ISET, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R10 assignment readback
    wr(A_ASGN, 32'hA5C3_0F12);
    rdchk("R10 assign", A_ASGN, 32'hA5C3_0F12);

    // R3 set/clear pairs
    wr(A_MSET, 32'h0000_F00F); wr(A_MSET, 32'h00F0_0000);
    rdchk("R3 mask set", A_MSET, 32'h00F0_F00F);
    wr(A_MCLR, 32'h0000_000F);
    rdchk("R3 mask clr", A_MCLR, 32'h00F0_F000);
    wr(A_ESET, 32'h8000_0001); wr(A_ECLR, 32'h0000_0001);
    rdchk("R3 edge", A_ECLR, 32'h8000_0000);
    wr(A_ISET, 32'h0101_0000); wr(A_ICLR, 32'h0100_0000);
    rdchk("R3 inv", A_ISET, 32'h0001_0000);
    wr(A_MCLR, 32'hFFFF_FFFF); wr(A_ECLR, 32'hFFFF_FFFF); wr(A_ICLR, 32'hFFFF_FFFF);

    // R2 routing sweep
    for (int p = 0; p < NP; p++)
      for (int h = 0; h < 2; h++)
        pin_i[p*16 + h*8 +: 8] = pv(p, h);
    for (int iv = 0; iv < 2; iv++) begin
      wr(A_ICLR, 32'hFFFF_FFFF);
      if (iv == 1) wr(A_ISET, 32'h0F0F_0F0F);
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          exp = 32'hFFFF_FFFF;
          exp[b*8 +: 8] = 8'(c);
          wr(A_ASGN, exp);
          idle(3);
          exp = '0;
          if (c < NP) exp[b*8 +: 8] = pv(c, b % 2);
          if (iv == 1) exp = exp ^ 32'h0F0F_0F0F;
          rdchk("R2 route", A_SNS, exp);
        end
    end

    // edge mode setup
    pin_i = '0;
    wr(A_ICLR, 32'hFFFF_FFFF);
    wr(A_ASGN, 32'h0);
    wr(A_ESET, 32'hFFFF_FFFF);
    idle(4);
    wr(A_REQ, 32'hFFFF_FFFF);
    rdchk("R6 clear all", A_REQ, 32'h0);

    // R11 latency, R4 rising edge
    @(negedge clk);
    pin_i[0] = 1'b1; bus_addr = A_REQ;
    @(negedge clk); #1 chk("R11 edge1", bus_rdata, 32'h0);
    @(negedge clk); #1 chk("R11 edge2", bus_rdata, 32'h0);
    @(negedge clk); #1 chk("R11 edge3", bus_rdata, 32'h0001_0001);
    pin_i[0] = 1'b0; idle(4);
    rdchk("R4 latched", A_REQ, 32'h0001_0001);
    chk("R9 masked", {31'b0, irq_o}, 32'h0);
    wr(A_MSET, 32'h0000_0001);
    chk("R9 unmasked", {31'b0, irq_o}, 32'h1);
    wr(A_REQ, 32'h0000_0001);
    rdchk("R6 partial", A_REQ, 32'h0001_0000);
    chk("R9 cleared", {31'b0, irq_o}, 32'h0);
    wr(A_REQ, 32'hFFFF_FFFF);
    wr(A_MCLR, 32'hFFFF_FFFF);

    // R5 invert toggle, R4 falling edge
    wr(A_ISET, 32'h0002_0002); idle(4);
    rdchk("R5 inv no event", A_REQ, 32'h0);
    pin_i[1] = 1'b1; idle(4);
    rdchk("R4 rise ignored", A_REQ, 32'h0);
    pin_i[1] = 1'b0; idle(4);
    rdchk("R4 falling", A_REQ, 32'h0002_0002);
    wr(A_REQ, 32'hFFFF_FFFF);

    // R8 edge coincides with clear
    @(negedge clk); pin_i[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_REQ; bus_wdata = 32'h0004_0004; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rdchk("R8 edge wins", A_REQ, 32'h0004_0004);
    pin_i = '0;

    // R7 level mode
    wr(A_ECLR, 32'hFFFF_FFFF); wr(A_ICLR, 32'hFFFF_FFFF); idle(4);
    wr(A_REQ, 32'hFFFF_FFFF);
    rdchk("R7 idle", A_REQ, 32'h0);
    pin_i[3] = 1'b1; idle(4);
    rdchk("R7 level", A_REQ, 32'h0008_0008);
    wr(A_REQ, 32'h0008_0008);
    rdchk("R7 clear held", A_REQ, 32'h0008_0008);
    pin_i[3] = 1'b0; idle(4);
    rdchk("R7 latched", A_REQ, 32'h0008_0008);
    wr(A_REQ, 32'h0008_0008);
    rdchk("R7 cleared", A_REQ, 32'h0);
    wr(A_ISET, 32'h0000_0010); idle(2);
    rdchk("R7 active low", A_REQ, 32'h0000_0010);
    wr(A_MSET, 32'h0000_0010);
    chk("R9 level irq", {31'b0, irq_o}, 32'h1);
    wr(A_MCLR, 32'h0000_0010);
    chk("R9 mask off", {31'b0, irq_o}, 32'h0);
    rdchk("R9 still pending", A_REQ, 32'h0000_0010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule